// File: doc/BRIEF.md
# DS3 Far-End Alarm and Control Code Receiver

This block recovers alarm and control code words sent over the one-bit-per-frame far-end channel of a DS3 C-bit parity stream. A framer upstream hands it one channel bit together with a strobe once per DS3 frame. The block keeps the last sixteen channel bits in a sliding window. When that window holds a well-formed message, it extracts the six-bit code word. Each message the block sees, good or missing, goes into a short history. From that history the block decides when a code is established and when it has gone away.

An established code is written into an eight-bit status register that the host reads. The block then raises a one-cycle validation event and sets a sticky interrupt flag, which stays set until the host clears it. When an established code stops arriving, the block gives a one-cycle removal event and drops its valid status. The register keeps the last established code.

Top module: `feac_rx`

## Requirements
- R1: While `rst_ni` is low, and directly after it rises, `code_reg_o` is 0x00 and `code_valid_o`, `valid_evt_o`, `remove_evt_o` and `int_o` are all 0.
- R2: The channel state moves only on a clock edge where `frame_stb_i` is high. Changes on `feac_bit_i` without the strobe have no effect on any output.
- R3: A message is recognised from sixteen bits in arrival order: eight 1s, then a 0, then code bits D0, D1, D2, D3, D4 and D5, then a 0.
- R4: The match is tested after every strobe on the latest sixteen bits, so a message is found at any bit alignment after arbitrary leading bits.
- R5: `code_reg_o[6:1]` holds the code with D0 at bit 1 and D5 at bit 6. Bits 7 and 0 are always 0.
- R6: All 64 code values, including 0x00 and 0x3F, are accepted and stored unchanged.
- R7: When no code is established and the same code makes up 8 of the last 10 message slots, that code is written to `code_reg_o`, `code_valid_o` is set, and `valid_evt_o` pulses high for one cycle. Each of these outputs appears two clock edges after the strobe that completed the message.
- R8: When a code is established and 3 of the last 10 message slots hold a different code or no message, `remove_evt_o` pulses for one cycle and `code_valid_o` clears. `code_reg_o` keeps its value.
- R9: Sixteen strobes in a row without a recognised message fill one message slot marked as failed.
- R10: `int_o` is set by each validation and cleared only by `int_clr_i`. If both happen in the same cycle, the set wins.
- R11: `valid_evt_o` and `remove_evt_o` are never high in the same cycle, and each is high only two edges after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One-cycle strobe per DS3 frame |
| feac_bit_i | input | 1 | Far-end channel bit, valid with the strobe |
| int_clr_i | input | 1 | Host clear of the sticky interrupt flag |
| code_reg_o | output | 8 | Status register holding the established code in bits 6:1 |
| code_valid_o | output | 1 | A code is currently established |
| valid_evt_o | output | 1 | One-cycle pulse when a code is established |
| remove_evt_o | output | 1 | One-cycle pulse when the established code is removed |
| int_o | output | 1 | Sticky interrupt flag |

## Verification
The assertions take two things for granted. First, `frame_stb_i` is held low during reset. Second, strobes are spaced at least two clocks apart, which keeps the two-edge event latency unambiguous. `int_clr_i` is assumed to be a host action and not tied to the strobe timing. The stimulus drives each strobe for one clock and then leaves two idle clocks, and it keeps every input low while reset is asserted. Messages start at odd alignments, are mixed with foreign codes, and are followed by long runs of ones, so the removal path through missing messages is reached.

// File: rtl/feac_rx_pkg.sv
package feac_rx_pkg;
  localparam int unsigned FEAC_CODE_W = 6;
  localparam int unsigned FEAC_ONES_N = 8;
  localparam int unsigned FEAC_HIST_N = 10;
  localparam int unsigned FEAC_VAL_TH = 8;
  localparam int unsigned FEAC_REM_TH = 3;
  localparam int unsigned FEAC_REG_W  = 8;
endpackage

// File: rtl/feac_rx_framer.sv
module feac_rx_framer #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned ONES_N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              bit_i,
  output logic              evt_o,
  output logic              ok_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned MSG_W  = ONES_N + CODE_W + 2;
  localparam int unsigned SLOT_W = $clog2(MSG_W);

  logic [MSG_W-2:0]  sr_q;
  logic [MSG_W-1:0]  sr_d;
  logic [CODE_W-1:0] code_w;
  logic [SLOT_W-1:0] slot_q;
  logic              match_w;
  logic              slot_end_w;

  // newest bit at position 0
  assign sr_d = {sr_q, bit_i};

  for (genvar i = 0; i < CODE_W; i++) begin : g_code
    assign code_w[i] = sr_d[CODE_W - i];
  end

  assign match_w = (sr_d[MSG_W-1 -: ONES_N] == {ONES_N{1'b1}}) &&
                   !sr_d[CODE_W+1] && !sr_d[0];
  assign slot_end_w = (slot_q == SLOT_W'(MSG_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      slot_q <= '0;
      evt_o  <= 1'b0;
      ok_o   <= 1'b0;
      code_o <= '0;
    end else begin
      evt_o <= 1'b0;
      if (stb_i) begin
        sr_q <= sr_d[MSG_W-2:0];
        if (match_w) begin
          slot_q <= '0;
          evt_o  <= 1'b1;
          ok_o   <= 1'b1;
          code_o <= code_w;
        end else if (slot_end_w) begin
          slot_q <= '0;
          evt_o  <= 1'b1;
          ok_o   <= 1'b0;
          code_o <= '0;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/feac_rx_qual.sv
module feac_rx_qual #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned HIST_N = 10,
  parameter int unsigned VAL_TH = 8,
  parameter int unsigned REM_TH = 3,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              ok_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              int_clr_i,
  output logic [REG_W-1:0]  reg_o,
  output logic              valid_o,
  output logic              val_evt_o,
  output logic              rem_evt_o,
  output logic              int_o
);
  localparam int unsigned HIST_D = HIST_N - 1;
  localparam int unsigned CNT_W  = $clog2(HIST_N + 1);

  logic              hist_ok_q   [HIST_D];
  logic [CODE_W-1:0] hist_code_q [HIST_D];
  logic [CODE_W-1:0] held_q;
  logic [CNT_W-1:0]  hit_cnt, miss_cnt;
  logic              do_val, do_rem;

  // counts over the incoming slot plus the stored ones
  always_comb begin
    hit_cnt  = CNT_W'(ok_i);
    miss_cnt = CNT_W'(!ok_i || (code_i != held_q));
    for (int j = 0; j < int'(HIST_D); j++) begin
      hit_cnt  = hit_cnt  + CNT_W'(hist_ok_q[j] && (hist_code_q[j] == code_i));
      miss_cnt = miss_cnt + CNT_W'(!hist_ok_q[j] || (hist_code_q[j] != held_q));
    end
  end

  assign do_val = evt_i && !valid_o && ok_i && (hit_cnt >= CNT_W'(VAL_TH));
  assign do_rem = evt_i && valid_o && (miss_cnt >= CNT_W'(REM_TH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < int'(HIST_D); j++) begin
        hist_ok_q[j]   <= 1'b0;
        hist_code_q[j] <= '0;
      end
    end else if (evt_i) begin
      hist_ok_q[0]   <= ok_i;
      hist_code_q[0] <= code_i;
      for (int j = 1; j < int'(HIST_D); j++) begin
        hist_ok_q[j]   <= hist_ok_q[j-1];
        hist_code_q[j] <= hist_code_q[j-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q    <= '0;
      valid_o   <= 1'b0;
      val_evt_o <= 1'b0;
      rem_evt_o <= 1'b0;
      int_o     <= 1'b0;
    end else begin
      val_evt_o <= do_val;
      rem_evt_o <= do_rem;
      if (do_val) begin
        held_q  <= code_i;
        valid_o <= 1'b1;
      end else if (do_rem) begin
        valid_o <= 1'b0;
      end
      if (do_val)         int_o <= 1'b1;
      else if (int_clr_i) int_o <= 1'b0;
    end
  end

  assign reg_o = {{(REG_W-CODE_W-1){1'b0}}, held_q, 1'b0};
endmodule

// File: rtl/feac_rx.sv
module feac_rx
  import feac_rx_pkg::*;
#(
  parameter int unsigned CODE_W = FEAC_CODE_W,
  parameter int unsigned ONES_N = FEAC_ONES_N,
  parameter int unsigned HIST_N = FEAC_HIST_N,
  parameter int unsigned VAL_TH = FEAC_VAL_TH,
  parameter int unsigned REM_TH = FEAC_REM_TH,
  parameter int unsigned REG_W  = FEAC_REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_stb_i,
  input  logic             feac_bit_i,
  input  logic             int_clr_i,
  output logic [REG_W-1:0] code_reg_o,
  output logic             code_valid_o,
  output logic             valid_evt_o,
  output logic             remove_evt_o,
  output logic             int_o
);
  logic              msg_evt;
  logic              msg_ok;
  logic [CODE_W-1:0] msg_code;

  feac_rx_framer #(.CODE_W(CODE_W), .ONES_N(ONES_N)) u_framer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (frame_stb_i),
    .bit_i  (feac_bit_i),
    .evt_o  (msg_evt),
    .ok_o   (msg_ok),
    .code_o (msg_code)
  );

  feac_rx_qual #(
    .CODE_W(CODE_W), .HIST_N(HIST_N), .VAL_TH(VAL_TH),
    .REM_TH(REM_TH), .REG_W(REG_W)
  ) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (msg_evt),
    .ok_i      (msg_ok),
    .code_i    (msg_code),
    .int_clr_i (int_clr_i),
    .reg_o     (code_reg_o),
    .valid_o   (code_valid_o),
    .val_evt_o (valid_evt_o),
    .rem_evt_o (remove_evt_o),
    .int_o     (int_o)
  );
endmodule

// File: rtl/feac_rx_sva.sv
module feac_rx_sva #(
  parameter int unsigned REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_stb_i,
  input logic             int_clr_i,
  input logic [REG_W-1:0] code_reg_o,
  input logic             code_valid_o,
  input logic             valid_evt_o,
  input logic             remove_evt_o,
  input logic             int_o
);
  a_r5_reg_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_reg_o[REG_W-1] && !code_reg_o[0]);
  a_r7_rise_has_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(code_valid_o) |-> valid_evt_o);
  a_r7_evt_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_evt_o |-> code_valid_o);
  a_r8_fall_has_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(code_valid_o) |-> remove_evt_o);
  a_r8_reg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_evt_o |-> $stable(code_reg_o));
  a_r10_int_on_val: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_evt_o |-> int_o);
  a_r10_int_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_o) |-> $past(int_clr_i));
  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_evt_o && remove_evt_o));
  a_r11_val_after_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_evt_o |-> $past(frame_stb_i, 2));
  a_r11_rem_after_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remove_evt_o |-> $past(frame_stb_i, 2));
endmodule

bind feac_rx feac_rx_sva #(.REG_W(REG_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_stb_i  (frame_stb_i),
  .int_clr_i    (int_clr_i),
  .code_reg_o   (code_reg_o),
  .code_valid_o (code_valid_o),
  .valid_evt_o  (valid_evt_o),
  .remove_evt_o (remove_evt_o),
  .int_o        (int_o)
);

// File: tb/feac_rx_tb.sv
`timescale 1ns/1ps
module feac_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, fbit = 1'b0, clr = 1'b0;
  logic [7:0] reg_o;
  logic       valid_o, vevt_o, revt_o, int_o;

  int checks = 0, errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  logic [7:0] exp_reg = 8'h00;
  bit exp_valid = 0, exp_vevt = 0, exp_revt = 0, exp_int = 0;
  logic bits[$];
  int   hist[$];
  int   since = 0;
  int   held = 0;

  always #2.5 clk = ~clk;

  feac_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_stb_i(stb), .feac_bit_i(fbit),
    .int_clr_i(clr), .code_reg_o(reg_o), .code_valid_o(valid_o),
    .valid_evt_o(vevt_o), .remove_evt_o(revt_o), .int_o(int_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      chk("R5 code_reg", int'(reg_o), int'(exp_reg));
      chk("R7/R8 code_valid", int'(valid_o), int'(exp_valid));
      chk("R7/R11 valid_evt", int'(vevt_o), int'(exp_vevt));
      chk("R8/R11 remove_evt", int'(revt_o), int'(exp_revt));
      chk("R10 int", int'(int_o), int'(exp_int));
    end
  end

  // behavioural reference
  task automatic model(input logic b);
    bit hit = 0;
    int ent = -1;
    bit evt = 0;
    bits.push_back(b);
    if (bits.size() > 16) void'(bits.pop_front());
    if (bits.size() == 16) begin
      hit = 1;
      for (int k = 0; k < 8; k++) if (bits[k] !== 1'b1) hit = 0;
      if (bits[8] !== 1'b0 || bits[15] !== 1'b0) hit = 0;
    end
    if (hit) begin
      ent = 0;
      for (int k = 0; k < 6; k++) if (bits[9+k] === 1'b1) ent += (1 << k);
      evt = 1; since = 0;
    end else begin
      since++;
      if (since == 16) begin evt = 1; ent = -1; since = 0; end
    end
    if (evt) begin
      hist.push_front(ent);
      void'(hist.pop_back());
      if (!exp_valid && ent >= 0) begin
        int n = 0;
        foreach (hist[k]) if (hist[k] == ent) n++;
        if (n >= 8) begin
          exp_valid = 1; exp_vevt = 1; exp_int = 1;
          held = ent; exp_reg = 8'(ent << 1);
        end
      end else if (exp_valid) begin
        int m = 0;
        foreach (hist[k]) if (hist[k] != held) m++;
        if (m >= 3) begin exp_valid = 0; exp_revt = 1; end
      end
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); stb = 1'b1; fbit = b;
    @(negedge clk); stb = 1'b0; fbit = ~b; model(b);
    @(negedge clk); exp_vevt = 0; exp_revt = 0;
  endtask

  task automatic send_msg(input int code, input int reps);
    for (int r = 0; r < reps; r++) begin
      for (int k = 0; k < 8; k++) send_bit(1'b1);
      send_bit(1'b0);
      for (int k = 0; k < 6; k++) send_bit(code[k]);
      send_bit(1'b0);
    end
  endtask

  task automatic host_clear();
    @(negedge clk); clr = 1'b1; exp_int = 0;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 10; k++) hist.push_back(-1);
    repeat (3) @(negedge clk);
    chk("R1 reset reg", int'(reg_o), 0);
    chk("R1 reset flags", int'({valid_o, vevt_o, revt_o, int_o}), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R2: bit wiggles without strobe
    repeat (20) begin @(negedge clk); fbit = ~fbit; end
    chk("R2 no strobe", int'({reg_o, valid_o, int_o}), 0);
    // R4: odd alignment then code 0x2D
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    send_msg(6'h2D, 7);
    chk("R7 not yet after 7", int'(valid_o), 0);
    send_msg(6'h2D, 1);
    chk("R3/R7 valid after 8", int'(valid_o), 1);
    chk("R5 reg 0x2D", int'(reg_o), 8'h5A);
    chk("R10 int set", int'(int_o), 1);
    host_clear();
    chk("R10 int cleared", int'(int_o), 0);
    // R8: foreign code removes
    send_msg(6'h2D, 2);
    send_msg(6'h12, 2);
    chk("R8 still valid after 2", int'(valid_o), 1);
    send_msg(6'h12, 1);
    chk("R8 removed after 3", int'(valid_o), 0);
    chk("R8 reg held", int'(reg_o), 8'h5A);
    send_msg(6'h12, 5);
    chk("R7 new code valid", int'(reg_o), 8'h24);
    // R6: extreme codes
    send_msg(6'h00, 10);
    chk("R6 code 0x00", int'({valid_o, reg_o}), 9'h100);
    send_msg(6'h3F, 10);
    chk("R6 code 0x3F", int'({valid_o, reg_o}), 9'h17E);
    // R9: idle ones remove
    for (int k = 0; k < 16 * 3; k++) send_bit(1'b1);
    chk("R9 removed by missing", int'(valid_o), 0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule